// File: doc/BRIEF.md
# Static Re-Reference Interval Replacement Engine

This block holds the replacement state of a set-associative cache and selects the way to evict on a miss. Each way of each set has a small prediction value. A value of zero means the line is expected to be used again soon. The all-ones value means reuse is expected only in the distant future. The cache controller sends one access event per cycle for one set: either a hit that names a way, or a miss. For a miss, the block returns the way to replace and the prediction value that way now holds.

A hit promotes its way in one of two ways, chosen by a static mode pin. In hit-priority mode the value is cleared to zero. In frequency-priority mode the value is reduced by one and stops at zero. On a miss the victim search ages the whole set. Instead of looping until some way reaches the maximum, the block adds, in one step, the distance between the set's largest value and the maximum. The victim is therefore always known two cycles after the request. A newly inserted line gets the maximum minus one, unless the controller supplies its own value. With a one-bit value width the block behaves as not-recently-used replacement.

Top module: `rrip_victim_sel`

## Requirements
- R1: While rst_n is low, vict_valid is 0. After reset every way of every set holds the maximum value (all ones), so successive misses to an untouched set pick ways 0, 1, 2, ... in order.
- R2: A miss accepted in cycle c (req_valid=1, req_hit=0 at the clock edge ending cycle c) raises vict_valid for exactly one cycle, in cycle c+2. A hit never raises vict_valid.
- R3: The victim is the lowest-index way whose value equals the maximum. If no way is at the maximum, the victim is the lowest-index way holding the largest value in the set.
- R4: A miss in a set with no way at the maximum raises every way of that set by (maximum − largest value). The order between ways is kept, and this shows in the victims chosen by later misses.
- R5: On a miss, the victim's value becomes ins_pv when ins_ovr_en=1, and the maximum minus one otherwise. vict_pv reports the value written.
- R6: With freq_mode=0, a hit sets the named way's value to 0.
- R7: With freq_mode=1, a hit lowers the named way's value by one, saturating at 0.
- R8: An access changes only the state of the set given by req_set.
- R9: A new request may be presented every cycle, including back-to-back requests to the same set. Each request sees the effect of all earlier ones.
- R10: With PV_BITS=1, a miss inserts 0 and takes the lowest-index way holding 1. If every way holds 0, all ways are set to 1 and way 0 is taken. A hit writes 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access event present this cycle |
| req_hit | input | 1 | 1 = hit on req_way, 0 = miss |
| req_way | input | WAY_W | Way that hit (ignored on a miss) |
| req_set | input | SET_BITS | Set addressed by the event |
| freq_mode | input | 1 | Static promotion mode: 0 = clear on hit, 1 = decrement on hit |
| ins_ovr_en | input | 1 | Use ins_pv as the insertion value |
| ins_pv | input | PV_BITS | Controller-supplied insertion value |
| vict_valid | output | 1 | Victim result present |
| vict_way | output | WAY_W | Way chosen for replacement |
| vict_pv | output | PV_BITS | Value written into the victim way |

## Verification
The hardest case to reach from the ports is a miss in a set where no way is at the maximum and the largest value is well below it, so that aging must add two or three in one step. The stimulus gets there in two ways. In clear-on-hit mode every way of a filled set is hit, which brings them all to zero. In decrement mode every way is hit once and one way twice, which leaves a mix of ones and a zero. A following miss then shows both the victim index and, through the next few misses, the values left in the other ways. A bench model that ages one step at a time, as the search is literally defined, predicts every result, including long pseudo-random mixed sequences issued back to back.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    // Hit promotion behaviour selected by the static mode pin
    typedef enum logic {
        PROMO_CLEAR = 1'b0,
        PROMO_DEC   = 1'b1
    } promo_e;

    // Index width that never collapses to zero bits
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rrip_row_max.sv
// Largest prediction value in one set
module rrip_row_max #(
    parameter int NUM_WAYS = 16,
    parameter int PV_BITS  = 2
) (
    input  logic [NUM_WAYS-1:0][PV_BITS-1:0] row_i,
    output logic [PV_BITS-1:0]               max_o
);
    always_comb begin
        max_o = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (row_i[w] > max_o) begin
                max_o = row_i[w];
            end
        end
    end
endmodule

// File: rtl/rrip_first_eq.sv
// Lowest-index way whose value equals the key
module rrip_first_eq #(
    parameter int NUM_WAYS = 16,
    parameter int PV_BITS  = 2,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_WAYS-1:0][PV_BITS-1:0] row_i,
    input  logic [PV_BITS-1:0]               key_i,
    output logic [IDX_W-1:0]                 idx_o
);
    always_comb begin
        idx_o = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (row_i[w] == key_i) begin
                idx_o = IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/rrip_row_next.sv
// Next contents of one set after a hit or a miss
module rrip_row_next #(
    parameter int NUM_WAYS = 16,
    parameter int PV_BITS  = 2,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_WAYS-1:0][PV_BITS-1:0] row_i,
    input  logic                             is_hit_i,
    input  logic [IDX_W-1:0]                 hit_way_i,
    input  rrip_pkg::promo_e                 promo_i,
    input  logic [PV_BITS-1:0]               step_i,
    input  logic [IDX_W-1:0]                 vict_i,
    input  logic [PV_BITS-1:0]               ins_i,
    output logic [NUM_WAYS-1:0][PV_BITS-1:0] row_o
);
    import rrip_pkg::*;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w);
        logic [PV_BITS-1:0] cur_v;
        logic [PV_BITS-1:0] promo_v;

        assign cur_v = row_i[w];

        always_comb begin
            if (promo_i == PROMO_DEC && cur_v != '0) begin
                promo_v = cur_v - PV_BITS'(1);
            end else begin
                promo_v = '0;
            end
        end

        always_comb begin
            if (is_hit_i) begin
                row_o[w] = (hit_way_i == MY_IDX) ? promo_v : cur_v;
            end else if (vict_i == MY_IDX) begin
                row_o[w] = ins_i;
            end else begin
                // never wraps: step is at most max minus the largest value
                row_o[w] = cur_v + step_i;
            end
        end
    end
endmodule

// File: rtl/rrip_victim_sel.sv
module rrip_victim_sel #(
    parameter int  NUM_WAYS = 16,
    parameter int  SET_BITS = 4,
    parameter int  PV_BITS  = 2,
    localparam int WAY_W    = rrip_pkg::idx_bits(NUM_WAYS),
    localparam int NUM_SETS = 1 << SET_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_hit,
    input  logic [WAY_W-1:0]    req_way,
    input  logic [SET_BITS-1:0] req_set,
    input  logic                freq_mode,
    input  logic                ins_ovr_en,
    input  logic [PV_BITS-1:0]  ins_pv,
    output logic                vict_valid,
    output logic [WAY_W-1:0]    vict_way,
    output logic [PV_BITS-1:0]  vict_pv
);
    import rrip_pkg::*;

    localparam logic [PV_BITS-1:0] PV_MAX  = '1;
    localparam logic [PV_BITS-1:0] PV_DFLT = PV_MAX - PV_BITS'(1);

    typedef logic [NUM_WAYS-1:0][PV_BITS-1:0] row_t;

    typedef struct packed {
        logic                    s1_vld;
        logic                    s1_hit;
        logic [WAY_W-1:0]        s1_way;
        logic [SET_BITS-1:0]     s1_set;
        logic [PV_BITS-1:0]      s1_ins;
        logic                    o_vld;
        logic [WAY_W-1:0]        o_way;
        logic [PV_BITS-1:0]      o_pv;
        row_t [NUM_SETS-1:0]     tab;
    } st_t;

    st_t st_d, st_q;

    row_t               cur_row;
    row_t               nxt_row;
    logic [PV_BITS-1:0] row_max;
    logic [PV_BITS-1:0] age_step;
    logic [WAY_W-1:0]   vict_idx;
    promo_e             promo;

    assign promo    = promo_e'(freq_mode);
    assign cur_row  = st_q.tab[st_q.s1_set];
    assign age_step = PV_MAX - row_max;

    rrip_row_max #(
        .NUM_WAYS (NUM_WAYS),
        .PV_BITS  (PV_BITS)
    ) i_max (
        .row_i (cur_row),
        .max_o (row_max)
    );

    // after aging, the ways holding the pre-aging largest value sit at max
    rrip_first_eq #(
        .NUM_WAYS (NUM_WAYS),
        .PV_BITS  (PV_BITS),
        .IDX_W    (WAY_W)
    ) i_scan (
        .row_i (cur_row),
        .key_i (row_max),
        .idx_o (vict_idx)
    );

    rrip_row_next #(
        .NUM_WAYS (NUM_WAYS),
        .PV_BITS  (PV_BITS),
        .IDX_W    (WAY_W)
    ) i_next (
        .row_i     (cur_row),
        .is_hit_i  (st_q.s1_hit),
        .hit_way_i (st_q.s1_way),
        .promo_i   (promo),
        .step_i    (age_step),
        .vict_i    (vict_idx),
        .ins_i     (st_q.s1_ins),
        .row_o     (nxt_row)
    );

    always_comb begin
        st_d        = st_q;
        // stage 1: capture the event
        st_d.s1_vld = req_valid;
        st_d.s1_hit = req_hit;
        st_d.s1_way = req_way;
        st_d.s1_set = req_set;
        st_d.s1_ins = ins_ovr_en ? ins_pv : PV_DFLT;
        // stage 2: update the set and publish the victim
        st_d.o_vld  = st_q.s1_vld && !st_q.s1_hit;
        st_d.o_way  = vict_idx;
        st_d.o_pv   = st_q.s1_ins;
        if (st_q.s1_vld) begin
            st_d.tab[st_q.s1_set] = nxt_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tab <= '1;
        end else begin
            st_q     <= st_d;
        end
    end

    assign vict_valid = st_q.o_vld;
    assign vict_way   = st_q.o_way;
    assign vict_pv    = st_q.o_pv;

    // R2
    vict_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vict_valid |-> $past(req_valid && !req_hit, 2));

    // R3
    vict_is_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_vld && !st_q.s1_hit) |-> (cur_row[vict_idx] == row_max));

    // R5
    ins_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.o_vld |-> (st_q.tab[$past(st_q.s1_set)][st_q.o_way] == st_q.o_pv));

    // R6
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_vld && st_q.s1_hit && !freq_mode)
        |=> (st_q.tab[$past(st_q.s1_set)][$past(st_q.s1_way)] == '0));

    // R7
    hit_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_vld && st_q.s1_hit && freq_mode)
        |=> (st_q.tab[$past(st_q.s1_set)][$past(st_q.s1_way)] ==
             (($past(cur_row[st_q.s1_way]) == '0) ? '0
                 : ($past(cur_row[st_q.s1_way]) - PV_BITS'(1)))));

endmodule

// File: tb/test_rrip_victim_sel.sv
`timescale 1ns/1ps
module test_rrip_victim_sel;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_hit, freq_mode, ins_ovr_en;
    logic [3:0] req_way, req_set;
    logic [1:0] ins_pv;
    logic       vict_valid;
    logic [3:0] vict_way;
    logic [1:0] vict_pv;

    logic       n_valid, n_hit, n_ovr;
    logic [1:0] n_way;
    logic [0:0] n_set, n_pv;
    logic       n_vv;
    logic [1:0] n_vw;
    logic [0:0] n_vp;

    always #2 clk = ~clk;

    rrip_victim_sel i_rrip_victim_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
        .req_way(req_way), .req_set(req_set), .freq_mode(freq_mode),
        .ins_ovr_en(ins_ovr_en), .ins_pv(ins_pv), .vict_valid(vict_valid),
        .vict_way(vict_way), .vict_pv(vict_pv)
    );

    rrip_victim_sel #(.NUM_WAYS(4), .SET_BITS(1), .PV_BITS(1)) i_rrip_victim_sel_nru (
        .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_hit(n_hit),
        .req_way(n_way), .req_set(n_set), .freq_mode(freq_mode),
        .ins_ovr_en(n_ovr), .ins_pv(n_pv), .vict_valid(n_vv),
        .vict_way(n_vw), .vict_pv(n_vp)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int mdl [0:1][0:15][0:15];
    int sq_set [0:511];
    int sq_hit [0:511];
    int sq_way [0:511];
    int sq_ovr [0:511];
    int sq_pv  [0:511];
    int ew     [0:511];
    int ep     [0:511];
    int sq_n;

    task automatic chk(input string req, input int av, input int aw, input int ap,
                       input int xv, input int xw, input int xp);
        bit ok;
        n_vec++;
        ok = (av == xv) && ((xv == 0) || (aw == xw && ap == xp));
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual valid=%0d way=%0d pv=%0d expected valid=%0d way=%0d pv=%0d",
                     req, av, aw, ap, xv, xw, xp);
        end
    endtask

    task automatic sq_clear();
        sq_n = 0;
    endtask

    task automatic sq_add(input int s, input int h, input int w, input int ov, input int pv);
        sq_set[sq_n] = s; sq_hit[sq_n] = h; sq_way[sq_n] = w;
        sq_ovr[sq_n] = ov; sq_pv[sq_n] = pv;
        sq_n++;
    endtask

    // Literal search: look for the maximum, age by one, repeat
    task automatic model_step(input int d, input int s, input int h, input int w,
                              input int ov, input int pv, output int xw, output int xp);
        int nw, mx, ins, vw;
        nw = (d != 0) ? 4 : 16;
        mx = (d != 0) ? 1 : 3;
        xw = 0; xp = 0;
        if (h != 0) begin
            if (freq_mode && mdl[d][s][w] > 0) mdl[d][s][w]--;
            else if (!freq_mode) mdl[d][s][w] = 0;
        end else begin
            ins = (ov != 0) ? pv : mx - 1;
            vw  = -1;
            for (int k = 0; k <= mx && vw < 0; k++) begin
                for (int x = nw - 1; x >= 0; x--)
                    if (mdl[d][s][x] == mx) vw = x;
                if (vw < 0)
                    for (int x = 0; x < nw; x++) mdl[d][s][x]++;
            end
            mdl[d][s][vw] = ins;
            xw = vw; xp = ins;
        end
    endtask

    // Issues the queued events back to back; output of event j appears two cycles later
    task automatic run_seq(input int d, input string req);
        for (int i = 0; i < sq_n + 3; i++) begin
            int j, av, aw, ap;
            @(negedge clk);
            j  = i - 2;
            av = (d != 0) ? int'(n_vv) : int'(vict_valid);
            aw = (d != 0) ? int'(n_vw) : int'(vict_way);
            ap = (d != 0) ? int'(n_vp) : int'(vict_pv);
            if (j >= 0 && j < sq_n && sq_hit[j] == 0) chk(req, av, aw, ap, 1, ew[j], ep[j]);
            else chk(req, av, aw, ap, 0, 0, 0);
            if (i < sq_n) begin
                model_step(d, sq_set[i], sq_hit[i], sq_way[i], sq_ovr[i], sq_pv[i], ew[i], ep[i]);
                if (d != 0) begin
                    n_valid = 1'b1; n_hit = (sq_hit[i] != 0); n_way = 2'(sq_way[i]);
                    n_set = 1'(sq_set[i]); n_ovr = (sq_ovr[i] != 0); n_pv = 1'(sq_pv[i]);
                end else begin
                    req_valid = 1'b1; req_hit = (sq_hit[i] != 0); req_way = 4'(sq_way[i]);
                    req_set = 4'(sq_set[i]); ins_ovr_en = (sq_ovr[i] != 0); ins_pv = 2'(sq_pv[i]);
                end
            end else begin
                req_valid = 1'b0;
                n_valid   = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", int'(vict_valid), 0, 0, 0, 0, 0);
            chk("R1", int'(n_vv), 0, 0, 0, 0, 0);
        end
        rst_n = 1'b1;
        sq_clear();
        sq_add(3, 0, 0, 0, 0);
        sq_add(3, 0, 0, 0, 0);
        sq_add(3, 0, 0, 0, 0);
        run_seq(0, "R1");
    endtask

    task automatic t_latency();
        sq_clear();
        sq_add(0, 0, 0, 0, 0);
        run_seq(0, "R2");
        sq_clear();
        sq_add(0, 1, 0, 0, 0);
        sq_add(0, 1, 5, 0, 0);
        run_seq(0, "R2");
    endtask

    task automatic t_fill_age();
        sq_clear();
        for (int i = 0; i < 17; i++) sq_add(5, 0, 0, 0, 0);
        run_seq(0, "R3");
        sq_clear();
        for (int i = 0; i < 4; i++) sq_add(6, 0, 0, 0, 0);
        sq_add(6, 1, 1, 0, 0);
        for (int i = 0; i < 15; i++) sq_add(6, 0, 0, 0, 0);
        run_seq(0, "R4");
    endtask

    task automatic t_hit_clear();
        freq_mode = 1'b0;
        sq_clear();
        for (int i = 0; i < 16; i++) sq_add(1, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) sq_add(1, 1, i, 0, 0);
        for (int i = 0; i < 4; i++) sq_add(1, 0, 0, 0, 0);
        run_seq(0, "R6");
    endtask

    task automatic t_freq();
        freq_mode = 1'b1;
        sq_clear();
        for (int i = 0; i < 16; i++) sq_add(4, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) sq_add(4, 1, i, 0, 0);
        sq_add(4, 1, 5, 0, 0);
        sq_add(4, 1, 5, 0, 0);
        sq_add(4, 1, 7, 0, 0);
        for (int i = 0; i < 18; i++) sq_add(4, 0, 0, 0, 0);
        run_seq(0, "R7");
        freq_mode = 1'b0;
    endtask

    task automatic t_override();
        sq_clear();
        sq_add(9, 0, 0, 1, 0);
        sq_add(9, 0, 0, 1, 3);
        sq_add(9, 0, 0, 1, 1);
        for (int i = 0; i < 16; i++) sq_add(9, 0, 0, 0, 0);
        run_seq(0, "R5");
    endtask

    task automatic t_interleave();
        sq_clear();
        for (int i = 0; i < 20; i++) begin
            sq_add(10, 0, 0, 0, 0);
            sq_add(11, (i % 3 == 0) ? 1 : 0, i % 16, 0, 0);
        end
        run_seq(0, "R8");
    endtask

    task automatic t_random();
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int m = 0; m < 2; m++) begin
            freq_mode = (m != 0);
            sq_clear();
            for (int i = 0; i < 150; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                sq_add(12 + int'(lf[1:0]), int'(lf[2] & lf[3]) | int'(lf[4] & lf[9]),
                       int'(lf[8:5]), int'(lf[11] & lf[12]), int'(lf[14:13]));
            end
            run_seq(0, "R9");
        end
        freq_mode = 1'b0;
    endtask

    task automatic t_nru();
        sq_clear();
        for (int i = 0; i < 5; i++) sq_add(0, 0, 0, 0, 0);
        sq_add(1, 0, 0, 0, 0);
        sq_add(0, 1, 2, 0, 0);
        for (int i = 0; i < 6; i++) sq_add(0, 0, 0, 0, 0);
        sq_add(1, 0, 0, 1, 1);
        sq_add(1, 0, 0, 0, 0);
        run_seq(1, "R10");
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b0; req_hit = 1'b0; req_way = '0; req_set = '0;
        freq_mode = 1'b0; ins_ovr_en = 1'b0; ins_pv = '0;
        n_valid = 1'b0; n_hit = 1'b0; n_way = '0; n_set = '0; n_ovr = 1'b0; n_pv = '0;
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 16; s++)
                for (int w = 0; w < 16; w++)
                    mdl[d][s][w] = (d != 0) ? 1 : 3;
        t_reset();
        t_latency();
        t_fill_age();
        t_hit_clear();
        t_freq();
        t_override();
        t_interleave();
        t_random();
        t_nru();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule